// File: doc/BRIEF.md
# Integer Multiply-Divide Unit with HI/LO Result Pair

This block carries out integer multiplication and division on two operands of WIDTH bits (32 by default), either as signed two's-complement or as unsigned values. Its results never go to a general register: they are kept in a private pair of result registers, HI and LO, and the datapath copies them out with separate move-from-HI and move-from-LO reads.

A multiply produces the full double-width product. The lower half lands in LO and the upper half in HI, one cycle after the operation is accepted. A divide is iterative and produces one quotient bit per cycle. A single operation yields both the quotient and the remainder: the quotient goes to LO and the remainder to HI.

A `busy` flag is high for as long as an operation is in flight. Operation strobes that arrive while `busy` is high are dropped. A read that arrives while `busy` is high is held inside the unit and served once the new results are in place.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy` and `rd_done` are 0, and both HI and LO read back as 0.
- R2: `op_code` bit 1 selects divide (1) or multiply (0), and bit 0 selects signed (1) or unsigned (0). An operation is accepted in a cycle with `op_valid` high and `busy` low, and `busy` is high in the following cycle.
- R3: A multiply writes the low WIDTH bits of the full 2*WIDTH-bit product to LO and the high WIDTH bits to HI. `busy` stays high for exactly 1 cycle.
- R4: A divide writes the quotient to LO and the remainder to HI. `busy` stays high for exactly WIDTH+1 cycles.
- R5: A signed divide rounds the quotient toward zero and gives the remainder the sign of the dividend. The most negative value divided by -1 gives a quotient equal to the most negative value and a remainder of 0.
- R6: A divide by zero, signed or unsigned, completes normally with LO all ones and HI equal to the dividend.
- R7: An `op_valid` strobe in a cycle where `busy` is high is ignored. Neither the running operation's length nor its results are affected.
- R8: A read request (`rd_req` high, `rd_hi`=1 for HI or 0 for LO) in a cycle with `busy` low is answered in the next cycle: `rd_done` is high for one cycle and `rd_data` holds the selected register.
- R9: A read request made while `busy` is high is held off. It is answered in the cycle after the first idle cycle, and it returns the new result of the operation that was in flight.
- R10: HI and LO change only when an operation completes. While the unit is idle, repeated reads return the same values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | Bit 1: divide/multiply; bit 0: signed/unsigned |
| op_a | input | WIDTH | Multiplicand or dividend |
| op_b | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | Operation in flight |
| rd_req | input | 1 | Move-from request |
| rd_hi | input | 1 | 1 selects HI, 0 selects LO |
| rd_done | output | 1 | Read answer strobe |
| rd_data | output | WIDTH | Read answer data |

## Verification
The unit is built with WIDTH=5, and every pair of operand values is applied under all four op codes. This sweep separates sign handling in the product halves from sign handling in the quotient, and it separates each remainder sign case. Divisor zero, the most-negative-by-minus-one corner and the all-ones operands all fall inside the sweep, along with checks on the busy length of every operation. Directed sequences then cover three cases: a read issued during a divide, which tells a held-off read apart from one served early with stale data; an operation strobe during busy, which must leave the earlier result intact; and repeated idle reads.

// File: rtl/muldiv_pkg.sv
// Shared types for the multiply-divide unit.
// Assumes: op code bit positions are fixed as listed below.
package muldiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2,
        ST_FIN  = 2'd3
    } md_state_e;

    localparam int OPC_DIV_BIT = 1;
    localparam int OPC_SGN_BIT = 0;
endpackage

// File: rtl/muldiv_operand_prep.sv
// Turns one operand into magnitude plus sign flag.
// Assumes: in unsigned mode the sign flag is 0 and the magnitude is the input.
// The most negative value keeps its bit pattern, which is its correct unsigned magnitude.
module muldiv_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    input  logic             is_signed,
    output logic [WIDTH-1:0] magnitude,
    output logic             negative
);
    // sign detect and conditional negate
    always_comb begin
        negative  = is_signed & value[WIDTH-1];
        magnitude = negative ? -value : value;
    end
endmodule

// File: rtl/muldiv_divider.sv
// Restoring shift-subtract divider on unsigned magnitudes, one quotient bit per step.
// Assumes: load and step are never high together; exactly WIDTH steps follow a load.
// With a zero divisor every trial succeeds, giving quotient all ones and remainder = dividend.
module muldiv_divider #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             last
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] part_q;
    logic [WIDTH-1:0] dsr_q;
    logic [CW-1:0]    cnt_q;
    logic [WIDTH:0]   shifted;
    logic [WIDTH-1:0] sub_res;
    logic             fits;

    // trial subtraction of divisor from shifted partial remainder
    always_comb begin
        shifted = {part_q, quo_q[WIDTH-1]};
        fits    = shifted >= {1'b0, dsr_q};
        sub_res = shifted[WIDTH-1:0] - dsr_q;
    end

    // iteration registers: quotient shifts in, partial remainder restores on failure
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q  <= '0;
            part_q <= '0;
            dsr_q  <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            quo_q  <= dividend;
            part_q <= '0;
            dsr_q  <= divisor;
            cnt_q  <= '0;
        end else if (step) begin
            quo_q  <= {quo_q[WIDTH-2:0], fits};
            part_q <= fits ? sub_res : shifted[WIDTH-1:0];
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // final step marker and result outputs
    always_comb begin
        last      = step && (cnt_q == CW'(WIDTH - 1));
        quotient  = quo_q;
        remainder = part_q;
    end
endmodule

// File: rtl/muldiv_sign_fix.sv
// Applies operand signs to the magnitude product, quotient and remainder.
// Assumes: sign flags are 0 for unsigned operations. The quotient is left
// unchanged on a zero divisor, so it stays all ones.
module muldiv_sign_fix #(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] mag_prod,
    input  logic [WIDTH-1:0]   mag_quo,
    input  logic [WIDTH-1:0]   mag_rem,
    input  logic               neg_a,
    input  logic               neg_b,
    input  logic               div_zero,
    output logic [WIDTH-1:0]   mul_hi,
    output logic [WIDTH-1:0]   mul_lo,
    output logic [WIDTH-1:0]   div_quo,
    output logic [WIDTH-1:0]   div_rem
);
    logic [2*WIDTH-1:0] prod_s;

    // signed result assembly
    always_comb begin
        prod_s  = (neg_a ^ neg_b) ? -mag_prod : mag_prod;
        mul_hi  = prod_s[2*WIDTH-1:WIDTH];
        mul_lo  = prod_s[WIDTH-1:0];
        div_quo = ((neg_a ^ neg_b) && !div_zero) ? -mag_quo : mag_quo;
        div_rem = neg_a ? -mag_rem : mag_rem;
    end
endmodule

// File: rtl/muldiv_result_regs.sv
// HI/LO result pair and the move-from read port.
// Assumes: busy is high from the cycle after acceptance up to and including the
// completion cycle. A read seen while busy is parked and served once idle.
module muldiv_result_regs #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_hi,
    input  logic [WIDTH-1:0] wr_lo,
    input  logic             busy,
    input  logic             rd_req,
    input  logic             rd_hi,
    output logic             rd_done,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] hi_q,
    output logic [WIDTH-1:0] lo_q
);
    logic pend_v;
    logic pend_hi;
    logic take_v;
    logic take_hi;

    // merge a fresh request with a parked one
    always_comb begin
        take_v  = rd_req | pend_v;
        take_hi = rd_req ? rd_hi : pend_hi;
    end

    // result pair update on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (wr_en) begin
            hi_q <= wr_hi;
            lo_q <= wr_lo;
        end
    end

    // read service or hold-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_done <= 1'b0;
            rd_data <= '0;
            pend_v  <= 1'b0;
            pend_hi <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            if (take_v && !busy) begin
                rd_done <= 1'b1;
                rd_data <= take_hi ? hi_q : lo_q;
                pend_v  <= 1'b0;
            end else if (take_v) begin
                pend_v  <= 1'b1;
                pend_hi <= take_hi;
            end
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
// Integer multiply-divide unit with a dedicated HI/LO result pair.
// Assumes: a multiply completes in one busy cycle, and a divide in WIDTH
// iteration cycles plus one sign-fix cycle. Strobes seen while busy are dropped.
module muldiv_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             busy,
    input  logic             rd_req,
    input  logic             rd_hi,
    output logic             rd_done,
    output logic [WIDTH-1:0] rd_data
);
    import muldiv_pkg::*;

    md_state_e          state_q;
    logic [WIDTH-1:0]   mag_a, mag_b, mag_a_q, mag_b_q;
    logic               neg_a, neg_b, neg_a_q, neg_b_q, bzero_q;
    logic               accept, div_start, div_step, div_last;
    logic [WIDTH-1:0]   quo, rem;
    logic [2*WIDTH-1:0] mag_prod;
    logic [WIDTH-1:0]   mul_hi, mul_lo, div_quo, div_rem;
    logic               wr_en;
    logic [WIDTH-1:0]   wr_hi, wr_lo;
    logic [WIDTH-1:0]   hi_q, lo_q;

    muldiv_operand_prep #(.WIDTH(WIDTH)) u_prep_a (
        .value(op_a), .is_signed(op_code[OPC_SGN_BIT]),
        .magnitude(mag_a), .negative(neg_a));

    muldiv_operand_prep #(.WIDTH(WIDTH)) u_prep_b (
        .value(op_b), .is_signed(op_code[OPC_SGN_BIT]),
        .magnitude(mag_b), .negative(neg_b));

    // acceptance and divider control
    always_comb begin
        busy      = (state_q != ST_IDLE);
        accept    = op_valid && !busy;
        div_start = accept && op_code[OPC_DIV_BIT];
        div_step  = (state_q == ST_DIV);
    end

    muldiv_divider #(.WIDTH(WIDTH)) u_div (
        .clk(clk), .rst_n(rst_n), .load(div_start), .step(div_step),
        .dividend(mag_a), .divisor(mag_b),
        .quotient(quo), .remainder(rem), .last(div_last));

    // operand capture and sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mag_a_q <= '0;
            mag_b_q <= '0;
            neg_a_q <= 1'b0;
            neg_b_q <= 1'b0;
            bzero_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    mag_a_q <= mag_a;
                    mag_b_q <= mag_b;
                    neg_a_q <= neg_a;
                    neg_b_q <= neg_b;
                    bzero_q <= (op_b == '0);
                    state_q <= op_code[OPC_DIV_BIT] ? ST_DIV : ST_MUL;
                end
                ST_MUL:  state_q <= ST_IDLE;
                ST_DIV:  if (div_last) state_q <= ST_FIN;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // magnitude product of captured operands
    always_comb begin
        mag_prod = {{WIDTH{1'b0}}, mag_a_q} * {{WIDTH{1'b0}}, mag_b_q};
    end

    muldiv_sign_fix #(.WIDTH(WIDTH)) u_fix (
        .mag_prod(mag_prod), .mag_quo(quo), .mag_rem(rem),
        .neg_a(neg_a_q), .neg_b(neg_b_q), .div_zero(bzero_q),
        .mul_hi(mul_hi), .mul_lo(mul_lo), .div_quo(div_quo), .div_rem(div_rem));

    // result selection on completion
    always_comb begin
        wr_en = (state_q == ST_MUL) || (state_q == ST_FIN);
        wr_hi = (state_q == ST_MUL) ? mul_hi : div_rem;
        wr_lo = (state_q == ST_MUL) ? mul_lo : div_quo;
    end

    muldiv_result_regs #(.WIDTH(WIDTH)) u_res (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .busy(busy), .rd_req(rd_req), .rd_hi(rd_hi),
        .rd_done(rd_done), .rd_data(rd_data), .hi_q(hi_q), .lo_q(lo_q));
endmodule

// File: rtl/muldiv_unit_chk.sv
// Checker for muldiv_unit: acceptance, busy lengths, read timing, result stability.
// Assumes: attached by the bind below; sees the result pair through the bind.
module muldiv_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             op_is_div,
    input logic             busy,
    input logic             rd_done,
    input logic [WIDTH-1:0] hi_q,
    input logic [WIDTH-1:0] lo_q
);
    localparam int LW = $clog2(WIDTH + 3) + 1;

    logic [LW-1:0] run_len;
    logic          was_div;

    // length of the current busy run and the kind of the last accepted op
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
            was_div <= 1'b0;
        end else begin
            if (op_valid && !busy) was_div <= op_is_div;
            run_len <= busy ? run_len + 1'b1 : '0;
        end
    end

    // R2
    op_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> busy);

    // R3 R4 R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == (was_div ? LW'(WIDTH + 1) : LW'(1))));

    // R8 R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !$past(busy));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_div(op_code[1]),
    .busy(busy), .rd_done(rd_done), .hi_q(hi_q), .lo_q(lo_q));

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [1:0]   op_code = 2'b00;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         busy;
    logic         rd_req = 1'b0, rd_hi = 1'b0;
    logic         rd_done;
    logic [W-1:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    muldiv_unit #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_a(op_a), .op_b(op_b), .busy(busy), .rd_req(rd_req), .rd_hi(rd_hi),
        .rd_done(rd_done), .rd_data(rd_data));

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint sval(input logic [W-1:0] v, input logic sgn);
        return (sgn && v[W-1]) ? longint'(v) - (longint'(1) << W) : longint'(v);
    endfunction

    task automatic expect_res(input logic [1:0] opc, input logic [W-1:0] a,
                              input logic [W-1:0] b, output logic [W-1:0] lo,
                              output logic [W-1:0] hi);
        longint sa = sval(a, opc[0]);
        longint sb = sval(b, opc[0]);
        longint p, q, r;
        if (!opc[1]) begin
            p  = sa * sb;
            lo = p[W-1:0];
            hi = p[2*W-1:W];
        end else if (b == '0) begin
            lo = '1;
            hi = a;
        end else begin
            q  = sa / sb;
            r  = sa % sb;
            lo = q[W-1:0];
            hi = r[W-1:0];
        end
    endtask

    // issue one op and return its busy length
    task automatic run_op(input logic [1:0] opc, input logic [W-1:0] a,
                          input logic [W-1:0] b, output int n);
        @(negedge clk);
        while (busy) @(negedge clk);
        op_valid = 1'b1; op_code = opc; op_a = a; op_b = b;
        @(negedge clk);
        op_valid = 1'b0;
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
    endtask

    // idle move-from read; rd_done expected one cycle later
    task automatic read_reg(input logic hi, input string tag, output logic [W-1:0] d);
        @(negedge clk);
        rd_req = 1'b1; rd_hi = hi;
        @(negedge clk);
        rd_req = 1'b0;
        chk(tag, rd_done, 1);
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] d, d2, elo, ehi;
        int n;
        string tag;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 rd_done", rd_done, 0);
        rst_n = 1'b1;
        read_reg(1'b0, "R1", d); chk("R1 LO", d, 0);
        read_reg(1'b1, "R1", d); chk("R1 HI", d, 0);

        // R2 busy rises the cycle after acceptance
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'b00; op_a = 5'd3; op_b = 5'd4;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R2 busy after accept", busy, 1);
        @(negedge clk);

        // exhaustive sweep: R3 multiply, R4 unsigned divide, R5 signed divide, R6 zero divisor
        for (int opc = 0; opc < 4; opc++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    if (opc < 2)           tag = "R3";
                    else if (b == 0)       tag = "R6";
                    else if (opc == 3)     tag = "R5";
                    else                   tag = "R4";
                    run_op(opc[1:0], a[W-1:0], b[W-1:0], n);
                    chk({tag, " busy length"}, n, (opc < 2) ? 1 : W + 1);
                    expect_res(opc[1:0], a[W-1:0], b[W-1:0], elo, ehi);
                    read_reg(1'b0, tag, d);
                    if (d !== elo) begin
                        $display("  op=%0d a=%0d b=%0d LO", opc, a, b);
                    end
                    chk({tag, " LO"}, d, elo);
                    read_reg(1'b1, tag, d);
                    chk({tag, " HI"}, d, ehi);
                end
            end
        end

        // R9 read issued during a divide is held off and returns the new remainder
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'b10; op_a = 5'd13; op_b = 5'd3;
        @(negedge clk);
        op_valid = 1'b0; rd_req = 1'b1; rd_hi = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        n = 0;
        while (!rd_done && n < 50) begin n++; @(negedge clk); end
        chk("R9 held-off latency", n, W + 1);
        chk("R9 held-off data", rd_data, 1);

        // R7 strobe during busy is ignored
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'b10; op_a = 5'd29; op_b = 5'd4;
        @(negedge clk);
        op_code = 2'b00; op_a = 5'd3; op_b = 5'd3;
        @(negedge clk);
        op_valid = 1'b0;
        n = 1;
        while (busy && n < 100) begin n++; @(negedge clk); end
        chk("R7 busy length", n, W + 1);
        read_reg(1'b0, "R7", d); chk("R7 LO", d, 7);
        read_reg(1'b1, "R7", d); chk("R7 HI", d, 1);

        // R8 one-cycle answer, R10 idle reads stable
        read_reg(1'b0, "R8", d);
        @(negedge clk);
        chk("R8 rd_done single pulse", rd_done, 0);
        repeat (5) @(negedge clk);
        read_reg(1'b0, "R10", d2);
        chk("R10 LO stable", d2, d);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule